// File: doc/BRIEF.md
# Frame Buffer and Palette Fetch Sequencer

This block is the memory fetch engine of a display controller. It reads a colour lookup table, frame pixel words, or both, from memory, using fixed-length bursts bounded by programmed start and inclusive end addresses. Fetched words go into a small output FIFO. Each word carries a flag that marks it as a palette word or a pixel word. A downstream consumer drains the FIFO one word per request.

The sequencer can load the palette and then stream pixels, load only the palette, or stream only pixels. When pixels run out of one frame window, the block either wraps to the start of the same buffer or switches to a second buffer. Frame completion, palette completion, FIFO starvation and an external sync-loss event are recorded in a status vector. Software clears that vector by writing ones to the bits it wants cleared. A single interrupt line combines the enabled events.

Top module: `fbpal_dma_seq`

## Requirements
- R1: After reset, `status` is zero, `irq` is low, `memReq` is low and `outData` is zero.
- R2: `burstCode` values 0, 1, 2, 3 and 4 select bursts of 1, 2, 4, 8 and 16 words. With codes 5 to 7, no memory request is ever issued.
- R3: Window end addresses are inclusive, and a burst is shortened so that its last word lands on the end word. Words leave the FIFO in ascending address order, and the next burst after a window end starts at a window start address.
- R4: When the last word of buffer 0 arrives, status bit 8 is set. With `dualBuf` low, fetching then restarts at `fb0Base`, and status bit 9 is never set.
- R5: With `dualBuf` high, fetching alternates between buffer 0 and buffer 1. The last word of buffer 1 sets status bit 9.
- R6: `loadMode` selects the sequence: 0 fetches the palette and then pixels, 1 fetches only the palette, 2 fetches only pixels, and 3 fetches nothing.
- R7: The palette window is 32 bytes when `bpp8` is low and 512 bytes when it is high, starting at `palBase`. Palette words leave with `outPal` high. Status bit 6 is set when the last palette word arrives.
- R8: In mode 1, once the palette is done no further request is issued. If status bit 6 is cleared while `rasterEn` is still high, the palette load runs again and sets bit 6 again. If it is cleared after `rasterEn` has dropped, it stays clear and no fetch follows.
- R9: If `outReady` is high while the FIFO is empty and `rasterEn` is high, `outData` is zero for that request and status bit 5 is set.
- R10: A cycle with `stsClrWr` high clears exactly the status bits that are one in `stsClrData`. If an event sets a bit in the same cycle that clears it, the bit stays set.
- R11: A one-cycle pulse on `syncLostIn` sets status bit 2.
- R12: `irq` is high when any of these holds: status bit 6 and `palDoneIe`; status bit 5 or bit 2, and `underflowIe`; status bit 8 or bit 9, and `eofIe`.
- R13: While `rasterEn` is low, no request is issued; a burst already accepted is still received. Once the sequencer is idle and disabled, the FIFO is emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasterEn | input | 1 | Run enable for the sequencer |
| loadMode | input | 2 | 0 palette+pixels, 1 palette only, 2 pixels only, 3 none |
| burstCode | input | 3 | Burst length code (0..4 valid) |
| dualBuf | input | 1 | Alternate between buffer 0 and buffer 1 |
| bpp8 | input | 1 | Selects the 512-byte palette instead of the 32-byte one |
| palDoneIe | input | 1 | Interrupt enable for palette done |
| underflowIe | input | 1 | Interrupt enable for underflow and sync loss |
| eofIe | input | 1 | Interrupt enable for frame ends |
| palBase | input | AW | Palette start byte address |
| fb0Base | input | AW | Buffer 0 start byte address |
| fb0Ceil | input | AW | Buffer 0 inclusive end byte address |
| fb1Base | input | AW | Buffer 1 start byte address |
| fb1Ceil | input | AW | Buffer 1 inclusive end byte address |
| stsClrWr | input | 1 | Status clear strobe |
| stsClrData | input | 10 | Ones select the status bits to clear |
| syncLostIn | input | 1 | Sync-loss event from the timing logic |
| memReq | output | 1 | Burst read request |
| memAddr | output | AW | Burst start byte address |
| memLen | output | 5 | Burst length in words |
| memAck | input | 1 | Request accepted |
| memValid | input | 1 | Read word valid |
| memData | input | DW | Read word |
| outReady | input | 1 | Consumer takes a word this cycle |
| outData | output | DW | Word at the FIFO head, or zero when the FIFO is empty |
| outPal | output | 1 | Head word is a palette word |
| status | output | 10 | Event status vector |
| irq | output | 1 | Combined interrupt |

## Verification
Two functions can act on the same status bit in the same cycle: an event setting it and a software clear of it. The bench provokes the collision on the underflow bit. It holds `outReady` high against an empty FIFO in the fetch-nothing mode, so the bit is set again on every cycle, and then issues a clear of that bit. The bit must still read one afterwards. Once `outReady` is dropped, the same clear must take the bit to zero. A second overlap is checked in mode 1, where clearing the palette-done bit while running must start a new palette fetch in the cycle of the clear.

// File: rtl/fbpal_pkg.sv
package fbpal_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_RECV,
    SQ_PHOLD
  } seqState_t;

  typedef struct packed {
    logic push;
    logic flush;
  } dpStrobe_t;

  localparam int ST_W        = 10;
  localparam int BIT_EOF1    = 9;
  localparam int BIT_EOF0    = 8;
  localparam int BIT_PALDONE = 6;
  localparam int BIT_UNDER   = 5;
  localparam int BIT_SYNC    = 2;

  localparam logic [ST_W-1:0] STAT_MASK =
    ST_W'((1 << BIT_EOF1) | (1 << BIT_EOF0) | (1 << BIT_PALDONE) |
          (1 << BIT_UNDER) | (1 << BIT_SYNC));

  localparam logic [1:0] LM_PAL_DATA  = 2'd0;
  localparam logic [1:0] LM_PAL_ONLY  = 2'd1;
  localparam logic [1:0] LM_DATA_ONLY = 2'd2;

  function automatic logic [4:0] burstWords(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd1;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      3'd4:    return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/fbpal_dpath.sv
module fbpal_dpath
  import fbpal_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [DW-1:0]    pushData,
  input  logic             pushPal,
  input  logic             outReady,
  input  logic             rasterEn,
  output logic [DW-1:0]    outData,
  output logic             outPal,
  output logic [LVL_W-1:0] level,
  output logic             underflowEvt
);

  localparam int PW = $clog2(DEPTH);

  logic [DW:0]      ram [DEPTH];
  logic [PW-1:0]    rdPtr, wrPtr;
  logic [LVL_W-1:0] levelQ;
  logic             empty, doPush, doPop;
  logic [DW:0]      head;

  always_comb begin
    empty        = (levelQ == '0);
    doPush       = strobe.push && !strobe.flush && (levelQ != LVL_W'(DEPTH));
    doPop        = outReady && !empty && !strobe.flush;
    head         = ram[rdPtr];
    outData      = empty ? '0 : head[DW-1:0];
    outPal       = !empty && head[DW];
    underflowEvt = outReady && empty && rasterEn;
    level        = levelQ;
  end

  always_ff @(posedge clk) begin
    if (doPush) ram[wrPtr] <= {pushPal, pushData};
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      levelQ <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + PW'(1);
      if (doPop)  rdPtr <= rdPtr + PW'(1);
      levelQ <= levelQ + LVL_W'(doPush) - LVL_W'(doPop);
    end
  end

endmodule

// File: rtl/fbpal_ctrl.sv
module fbpal_ctrl
  import fbpal_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int DEPTH     = 32,
  parameter int LVL_W     = 6,
  parameter int PAL_SMALL = 32,
  parameter int PAL_LARGE = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rasterEn,
  input  logic [1:0]       loadMode,
  input  logic [2:0]       burstCode,
  input  logic             dualBuf,
  input  logic             bpp8,
  input  logic             palDoneIe,
  input  logic             underflowIe,
  input  logic             eofIe,
  input  logic [AW-1:0]    palBase,
  input  logic [AW-1:0]    fb0Base,
  input  logic [AW-1:0]    fb0Ceil,
  input  logic [AW-1:0]    fb1Base,
  input  logic [AW-1:0]    fb1Ceil,
  input  logic             stsClrWr,
  input  logic [ST_W-1:0]  stsClrData,
  input  logic             syncLostIn,
  input  logic             memAck,
  input  logic             memValid,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic             underflowEvt,
  output logic             memReq,
  output logic [AW-1:0]    memAddr,
  output logic [4:0]       memLen,
  output dpStrobe_t        strobe,
  output logic             pushPal,
  output logic [ST_W-1:0]  status,
  output logic             irq
);

  localparam int BSH = $clog2(DW / 8);
  localparam int SW  = LVL_W + 1;

  seqState_t       state;
  logic [AW-1:0]   curAddr;
  logic            palPhase, curBuf, lastOfWin;
  logic [4:0]      burstLen, rcvCnt;
  logic [4:0]      bw, len;
  logic [AW-1:0]   palCeil, winCeil, remWords, nextBase;
  logic            room, modeOk, codeOk, lastWord, winEnd, nextBuf;
  logic            eof0Set, eof1Set, palSet;
  logic [ST_W-1:0] setVec, clrVec, statusQ;

  always_comb begin
    bw       = burstWords(burstCode);
    palCeil  = palBase + (bpp8 ? AW'(PAL_LARGE) : AW'(PAL_SMALL)) - AW'(1);
    winCeil  = palPhase ? palCeil : (curBuf ? fb1Ceil : fb0Ceil);
    remWords = ((winCeil - curAddr) >> BSH) + AW'(1);
    len      = (remWords < AW'(bw)) ? remWords[4:0] : bw;
    room     = ({1'b0, fifoLevel} + SW'(len)) <= SW'(DEPTH);
    modeOk   = (loadMode != 2'd3);
    codeOk   = (bw != 5'd0);
    memReq   = (state == SQ_REQ) && rasterEn && modeOk && codeOk && room;
    memAddr  = curAddr;
    memLen   = len;
    lastWord = (state == SQ_RECV) && memValid && (rcvCnt == burstLen - 5'd1);
    winEnd   = lastWord && lastOfWin;
    nextBuf  = dualBuf && !curBuf;
    nextBase = nextBuf ? fb1Base : fb0Base;
    palSet   = winEnd && palPhase;
    eof0Set  = winEnd && !palPhase && !curBuf;
    eof1Set  = winEnd && !palPhase && curBuf;
    strobe.push  = (state == SQ_RECV) && memValid;
    strobe.flush = (state == SQ_IDLE) && !rasterEn;
    pushPal  = palPhase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SQ_IDLE;
      curAddr   <= '0;
      palPhase  <= 1'b0;
      curBuf    <= 1'b0;
      lastOfWin <= 1'b0;
      burstLen  <= '0;
      rcvCnt    <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (rasterEn && modeOk && codeOk) begin
            state  <= SQ_REQ;
            curBuf <= 1'b0;
            if (loadMode == LM_DATA_ONLY) begin
              palPhase <= 1'b0;
              curAddr  <= fb0Base;
            end else begin
              palPhase <= 1'b1;
              curAddr  <= palBase;
            end
          end
        end
        SQ_REQ: begin
          if (!rasterEn) begin
            state <= SQ_IDLE;
          end else if (memReq && memAck) begin
            state     <= SQ_RECV;
            burstLen  <= len;
            rcvCnt    <= '0;
            lastOfWin <= (remWords <= AW'(bw));
            curAddr   <= curAddr + (AW'(len) << BSH);
          end
        end
        SQ_RECV: begin
          if (memValid) rcvCnt <= rcvCnt + 5'd1;
          if (lastWord) begin
            if (lastOfWin && palPhase && loadMode == LM_PAL_ONLY) begin
              state <= SQ_PHOLD;
            end else begin
              state <= rasterEn ? SQ_REQ : SQ_IDLE;
              if (lastOfWin) begin
                if (palPhase) begin
                  palPhase <= 1'b0;
                  curBuf   <= 1'b0;
                  curAddr  <= fb0Base;
                end else begin
                  curBuf  <= nextBuf;
                  curAddr <= nextBase;
                end
              end
            end
          end
        end
        SQ_PHOLD: begin
          if (!rasterEn) begin
            state <= SQ_IDLE;
          end else if (stsClrWr && stsClrData[BIT_PALDONE]) begin
            state   <= SQ_REQ;
            curAddr <= palBase;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    setVec              = '0;
    setVec[BIT_EOF1]    = eof1Set;
    setVec[BIT_EOF0]    = eof0Set;
    setVec[BIT_PALDONE] = palSet;
    setVec[BIT_UNDER]   = underflowEvt;
    setVec[BIT_SYNC]    = syncLostIn;
    clrVec              = stsClrWr ? (stsClrData & STAT_MASK) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrVec) | setVec;
  end

  always_comb begin
    status = statusQ;
    irq = (statusQ[BIT_PALDONE] && palDoneIe) ||
          ((statusQ[BIT_UNDER] || statusQ[BIT_SYNC]) && underflowIe) ||
          ((statusQ[BIT_EOF0] || statusQ[BIT_EOF1]) && eofIe);
  end

endmodule

// File: rtl/fbpal_dma_seq.sv
module fbpal_dma_seq
  import fbpal_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int FIFO_DEPTH = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            rasterEn,
  input  logic [1:0]      loadMode,
  input  logic [2:0]      burstCode,
  input  logic            dualBuf,
  input  logic            bpp8,
  input  logic            palDoneIe,
  input  logic            underflowIe,
  input  logic            eofIe,
  input  logic [AW-1:0]   palBase,
  input  logic [AW-1:0]   fb0Base,
  input  logic [AW-1:0]   fb0Ceil,
  input  logic [AW-1:0]   fb1Base,
  input  logic [AW-1:0]   fb1Ceil,
  input  logic            stsClrWr,
  input  logic [9:0]      stsClrData,
  input  logic            syncLostIn,
  output logic            memReq,
  output logic [AW-1:0]   memAddr,
  output logic [4:0]      memLen,
  input  logic            memAck,
  input  logic            memValid,
  input  logic [DW-1:0]   memData,
  input  logic            outReady,
  output logic [DW-1:0]   outData,
  output logic            outPal,
  output logic [9:0]      status,
  output logic            irq
);

  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  dpStrobe_t        strobe;
  logic             pushPal;
  logic [LVL_W-1:0] fifoLevel;
  logic             underflowEvt;

  fbpal_ctrl #(
    .AW(AW), .DW(DW), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .rasterEn(rasterEn), .loadMode(loadMode),
    .burstCode(burstCode), .dualBuf(dualBuf), .bpp8(bpp8),
    .palDoneIe(palDoneIe), .underflowIe(underflowIe), .eofIe(eofIe),
    .palBase(palBase), .fb0Base(fb0Base), .fb0Ceil(fb0Ceil),
    .fb1Base(fb1Base), .fb1Ceil(fb1Ceil), .stsClrWr(stsClrWr),
    .stsClrData(stsClrData), .syncLostIn(syncLostIn), .memAck(memAck),
    .memValid(memValid), .fifoLevel(fifoLevel), .underflowEvt(underflowEvt),
    .memReq(memReq), .memAddr(memAddr), .memLen(memLen), .strobe(strobe),
    .pushPal(pushPal), .status(status), .irq(irq)
  );

  fbpal_dpath #(
    .DW(DW), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushData(memData),
    .pushPal(pushPal), .outReady(outReady), .rasterEn(rasterEn),
    .outData(outData), .outPal(outPal), .level(fifoLevel),
    .underflowEvt(underflowEvt)
  );

endmodule

// File: rtl/fbpal_dma_seq_chk.sv
module fbpal_dma_seq_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             rasterEn,
  input logic [2:0]       burstCode,
  input logic             bpp8,
  input logic [AW-1:0]    palBase,
  input logic [AW-1:0]    fb0Base,
  input logic [AW-1:0]    fb0Ceil,
  input logic [AW-1:0]    fb1Base,
  input logic [AW-1:0]    fb1Ceil,
  input logic             stsClrWr,
  input logic             clrEof1,
  input logic             memReq,
  input logic [AW-1:0]    memAddr,
  input logic [4:0]       memLen,
  input logic             memAck,
  input logic             outReady,
  input logic [DW-1:0]    outData,
  input logic             eof1Sts,
  input logic             underSts,
  input logic [LVL_W-1:0] fifoLevel
);

  localparam int BSH = $clog2(DW / 8);

  logic [AW-1:0] lastA, palEnd;
  logic          inWin;

  always_comb begin
    lastA  = memAddr + (AW'(memLen - 5'd1) << BSH);
    palEnd = palBase + (bpp8 ? AW'(512) : AW'(32)) - AW'(1);
    inWin  = (memAddr >= fb0Base && lastA <= fb0Ceil) ||
             (memAddr >= fb1Base && lastA <= fb1Ceil) ||
             (memAddr >= palBase && lastA <= palEnd);
  end

  AST_BURST_CODE_OK: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (burstCode <= 3'd4)); // R2

  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memLen != 5'd0) && (memLen <= (5'd1 << burstCode))); // R2

  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> inWin); // R3

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> !memReq || $stable(memAddr)); // R3

  AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !rasterEn |-> !memReq); // R13

  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    outReady && rasterEn && (fifoLevel == '0) |=> underSts); // R9

  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outReady && (fifoLevel == '0) |-> (outData == '0)); // R9

  AST_EOF1_W1C: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eof1Sts) |-> $past(stsClrWr && clrEof1)); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(DEPTH)); // R3

endmodule

bind fbpal_dma_seq fbpal_dma_seq_chk #(
  .AW(AW), .DW(DW), .DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
) uChk (
  .clk(clk), .rstN(rstN), .rasterEn(rasterEn), .burstCode(burstCode),
  .bpp8(bpp8), .palBase(palBase), .fb0Base(fb0Base), .fb0Ceil(fb0Ceil),
  .fb1Base(fb1Base), .fb1Ceil(fb1Ceil), .stsClrWr(stsClrWr),
  .clrEof1(stsClrData[9]), .memReq(memReq), .memAddr(memAddr),
  .memLen(memLen), .memAck(memAck), .outReady(outReady), .outData(outData),
  .eof1Sts(status[9]), .underSts(status[5]), .fifoLevel(fifoLevel)
);

// File: tb/tb_fbpal_dma_seq.sv
module tb_fbpal_dma_seq;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rasterEn, dualBuf, bpp8, palDoneIe, underflowIe, eofIe;
  logic [1:0]  loadMode;
  logic [2:0]  burstCode;
  logic [31:0] palBase, fb0Base, fb0Ceil, fb1Base, fb1Ceil;
  logic        stsClrWr, syncLostIn;
  logic [9:0]  stsClrData;
  logic        memReq, memAck, memValid, outReady, outPal, irq;
  logic [31:0] memAddr, memData, outData;
  logic [4:0]  memLen;
  logic [9:0]  status;

  int          nChecks = 0;
  int          nFails  = 0;
  int          reqCount = 0;
  logic [31:0] logAddr [64];
  logic [4:0]  logLen  [64];

  always #5 clk = ~clk;

  fbpal_dma_seq dut (
    .clk(clk), .rstN(rstN), .rasterEn(rasterEn), .loadMode(loadMode),
    .burstCode(burstCode), .dualBuf(dualBuf), .bpp8(bpp8),
    .palDoneIe(palDoneIe), .underflowIe(underflowIe), .eofIe(eofIe),
    .palBase(palBase), .fb0Base(fb0Base), .fb0Ceil(fb0Ceil),
    .fb1Base(fb1Base), .fb1Ceil(fb1Ceil), .stsClrWr(stsClrWr),
    .stsClrData(stsClrData), .syncLostIn(syncLostIn), .memReq(memReq),
    .memAddr(memAddr), .memLen(memLen), .memAck(memAck),
    .memValid(memValid), .memData(memData), .outReady(outReady),
    .outData(outData), .outPal(outPal), .status(status), .irq(irq)
  );

  // memory responder: accepts a request, then returns len words whose value is their address
  initial begin
    logic [31:0] a;
    int n;
    memAck = 1'b0; memValid = 1'b0; memData = '0;
    forever begin
      @(negedge clk); #2;
      if (memReq && rstN) begin
        a = memAddr; n = int'(memLen);
        if (reqCount < 64) begin
          logAddr[reqCount] = a;
          logLen[reqCount]  = memLen;
        end
        reqCount++;
        memAck = 1'b1;
        @(negedge clk); #2;
        memAck = 1'b0;
        for (int i = 0; i < n; i++) begin
          memValid = 1'b1;
          memData  = a + 32'(4 * i);
          @(negedge clk); #2;
        end
        memValid = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clrSts(input logic [9:0] mask);
    stsClrWr = 1'b1; stsClrData = mask;
    tick(1);
    stsClrWr = 1'b0; stsClrData = '0;
  endtask

  task automatic quiesce();
    rasterEn = 1'b0; outReady = 1'b0;
    tick(40);
    clrSts(10'h3FF);
    tick(2);
  endtask

  task automatic pullWords(input int n, input logic [31:0] base, input logic pal, input string req);
    for (int i = 0; i < n; i++) begin
      outReady = 1'b1;
      #1;
      chk(req, outData, base + 32'(4 * i));
      chk(req, 32'(outPal), 32'(pal));
      @(negedge clk);
    end
    outReady = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 status", 32'(status), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 memReq", 32'(memReq), 0);
    chk("R1 outData", outData, 0);
  endtask

  task automatic tSingleBuffer();
    int b;
    b = reqCount;
    fb0Base = 32'h1000; fb0Ceil = 32'h1027;
    loadMode = 2'd2; burstCode = 3'd2; dualBuf = 1'b0;
    rasterEn = 1'b1;
    tick(100);
    chk("R2 four-word burst", 32'(logLen[b]), 4);
    chk("R3 burst addr 1", logAddr[b+1], 32'h1010);
    chk("R3 clipped len", 32'(logLen[b+2]), 2);
    chk("R3 clipped addr", logAddr[b+2], 32'h1020);
    chk("R4 wrap to base", logAddr[b+3], 32'h1000);
    chk("R4 eof0 set", 32'(status[8]), 1);
    chk("R4 eof1 clear", 32'(status[9]), 0);
    pullWords(10, 32'h1000, 1'b0, "R3 word order");
  endtask

  task automatic tUnderflow();
    int b;
    b = reqCount;
    loadMode = 2'd3; underflowIe = 1'b1; rasterEn = 1'b1;
    tick(20);
    chk("R6 mode3 no request", 32'(reqCount - b), 0);
    chk("R12 irq low before underflow", 32'(irq), 0);
    outReady = 1'b1;
    #1;
    chk("R13 FIFO flushed, R9 zero word", outData, 0);
    tick(2);
    chk("R9 underflow bit", 32'(status[5]), 1);
    chk("R12 irq underflow", 32'(irq), 1);
    clrSts(10'h020);
    #1;
    chk("R10 set wins over clear", 32'(status[5]), 1);
    outReady = 1'b0;
    tick(1);
    clrSts(10'h020);
    #1;
    chk("R10 clear", 32'(status[5]), 0);
    underflowIe = 1'b0;
  endtask

  task automatic tDual();
    int b;
    b = reqCount;
    fb0Base = 32'h1000; fb0Ceil = 32'h101F;
    fb1Base = 32'h2000; fb1Ceil = 32'h201F;
    loadMode = 2'd2; burstCode = 3'd3; dualBuf = 1'b1; eofIe = 1'b0;
    rasterEn = 1'b1;
    tick(80);
    chk("R2 eight-word burst", 32'(logLen[b]), 8);
    chk("R5 switch to buf1", logAddr[b+1], 32'h2000);
    chk("R5 back to buf0", logAddr[b+2], 32'h1000);
    chk("R5 eof1 set", 32'(status[9]), 1);
    chk("R4 eof0 set dual", 32'(status[8]), 1);
    chk("R12 irq masked", 32'(irq), 0);
    eofIe = 1'b1;
    #1;
    chk("R12 irq eof", 32'(irq), 1);
    clrSts(10'h100);
    #1;
    chk("R10 only eof0 cleared", 32'(status[8]), 0);
    chk("R10 eof1 kept", 32'(status[9]), 1);
    eofIe = 1'b0;
    pullWords(8, 32'h1000, 1'b0, "R5 buf0 words");
    pullWords(8, 32'h2000, 1'b0, "R5 buf1 words");
  endtask

  task automatic tPalThenData();
    int b;
    b = reqCount;
    palBase = 32'h3000; bpp8 = 1'b0;
    fb0Base = 32'h1000; fb0Ceil = 32'h103F; dualBuf = 1'b0;
    loadMode = 2'd0; burstCode = 3'd4;
    rasterEn = 1'b1;
    tick(70);
    chk("R7 palette first", logAddr[b], 32'h3000);
    chk("R7 palette 32 bytes", 32'(logLen[b]), 8);
    chk("R6 then data", logAddr[b+1], 32'h1000);
    chk("R2 sixteen-word burst", 32'(logLen[b+1]), 16);
    chk("R7 palette done", 32'(status[6]), 1);
    pullWords(8, 32'h3000, 1'b1, "R7 palette words");
    pullWords(4, 32'h1000, 1'b0, "R6 data after palette");
  endtask

  task automatic tPal8();
    int b;
    b = reqCount;
    palBase = 32'h3000; bpp8 = 1'b1; loadMode = 2'd1; burstCode = 3'd4;
    rasterEn = 1'b1;
    tick(70);
    chk("R7 large palette burst", 32'(logLen[b]), 16);
    chk("R7 large palette continues", logAddr[b+1], 32'h3040);
    chk("R7 not done yet", 32'(status[6]), 0);
    bpp8 = 1'b0;
  endtask

  task automatic tPalOnly();
    int b;
    b = reqCount;
    palBase = 32'h3000; bpp8 = 1'b0; loadMode = 2'd1; burstCode = 3'd3;
    palDoneIe = 1'b1;
    rasterEn = 1'b1;
    tick(40);
    chk("R8 one palette burst", 32'(reqCount - b), 1);
    chk("R8 palette done", 32'(status[6]), 1);
    chk("R12 irq palette", 32'(irq), 1);
    clrSts(10'h040);
    tick(40);
    chk("R8 refire load", 32'(reqCount - b), 2);
    chk("R8 refire addr", logAddr[b+1], 32'h3000);
    chk("R8 done again", 32'(status[6]), 1);
    rasterEn = 1'b0;
    tick(5);
    clrSts(10'h040);
    tick(40);
    chk("R8 clean clear", 32'(status[6]), 0);
    chk("R13 no request when disabled", 32'(reqCount - b), 2);
    palDoneIe = 1'b0;
  endtask

  task automatic tBadCode();
    int b;
    b = reqCount;
    loadMode = 2'd2; burstCode = 3'd5; rasterEn = 1'b1;
    tick(40);
    chk("R2 invalid code no request", 32'(reqCount - b), 0);
    chk("R2 memReq low", 32'(memReq), 0);
  endtask

  task automatic tSyncLost();
    underflowIe = 1'b1;
    syncLostIn = 1'b1;
    tick(1);
    syncLostIn = 1'b0;
    #1;
    chk("R11 sync lost bit", 32'(status[2]), 1);
    chk("R12 irq sync", 32'(irq), 1);
    clrSts(10'h004);
    #1;
    chk("R11 sync lost cleared", 32'(status[2]), 0);
    underflowIe = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; rasterEn = 1'b0; loadMode = 2'd0; burstCode = 3'd0;
    dualBuf = 1'b0; bpp8 = 1'b0; palDoneIe = 1'b0; underflowIe = 1'b0;
    eofIe = 1'b0; palBase = '0; fb0Base = '0; fb0Ceil = '0; fb1Base = '0;
    fb1Ceil = '0; stsClrWr = 1'b0; stsClrData = '0; syncLostIn = 1'b0;
    outReady = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    tReset();
    tSingleBuffer();
    quiesce();
    tUnderflow();
    quiesce();
    tDual();
    quiesce();
    tPalThenData();
    quiesce();
    tPal8();
    quiesce();
    tPalOnly();
    quiesce();
    tBadCode();
    quiesce();
    tSyncLost();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule